// File: doc/BRIEF.md
# Password-Gated Clock Configuration Register Bank

This block is the register file in front of a clock manager. Software writes 32-bit words over a simple write port. Each word carries an 8-bit key in its top byte. A write without the right key, or one that is not word-aligned, is dropped and flagged. An accepted write is stored with the key byte cleared. It then raises one-cycle refresh strobes, so the downstream PLL, post-divider channel and clock-select logic can pick up the new setting. The generation of the clocks themselves happens elsewhere.

Word 0 is a read-only status word. It is not stored. Each read computes it from the PLL manager and PLL control words: a PLL counts as locked when it is neither powered down nor held in analog reset. Each PLL manager word is shared between the PLL and its channels. A write to it therefore refreshes the PLL and all the channels that PLL feeds. Reads use a combinational port over the 0x2000-byte window. Reads of words past the implemented range, and misaligned reads, return zero.

Top module: `clkcfg_regs`

## Requirements
- R1: After a synchronous reset, word 0 reads 0x0. PLL manager words 1..5 read 0x00000100 (analog reset, bit 8, set). PLL control words 8..12 read 0x00010000 (power-down, bit 16, set). Channel words 16..25 read 0x00000100 (channel off, bit 8, set). Every other implemented word reads 0.
- R2: A write whose bits [31:24] differ from 0x5A changes no word and raises no strobe. It pulses wr_err high for exactly the one cycle after the write edge.
- R3: An accepted write to a writable word stores the data with bits [31:24] forced to zero. The new value is readable in the cycle after the write edge.
- R4: A write with wr_addr[1:0] not equal to 0 is rejected in the same way as R2, even when it carries the key.
- R5: An accepted write to writable word i (wr_addr[12:2] = i, 1 <= i < 32) drives upd_strobe[i] high for one cycle after the write edge, with every other upd_strobe bit low.
- R6: Word 0 reads bit p = 1 exactly when bit 8 of manager word 1+p and bit 16 of control word 8+p are both 0. PLLs are taken in the order A, C, D, H, B, which maps to p = 0..4. Bits 31:5 read 0.
- R7: A keyed write to word 0 or to a word at index 32 or above stores nothing, raises no strobe, and does not raise wr_err.
- R8: An accepted write to manager word 1+p pulses pll_refresh[p] together with chan_refresh[2p] and chan_refresh[2p+1]. A write to control word 8+p pulses only pll_refresh[p]. A write to channel word 16+c pulses only chan_refresh[c].
- R9: A read with rd_addr[1:0] not equal to 0, or with rd_addr[12:2] of 32 or more, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 32 | Write word, key in bits [31:24] |
| rd_addr | input | 13 | Byte address of the read |
| rd_data | output | 32 | Read word (combinational) |
| wr_err | output | 1 | Previous write was rejected |
| upd_strobe | output | 32 | Per-word update pulse |
| pll_refresh | output | 5 | Per-PLL refresh pulse |
| chan_refresh | output | 10 | Per-channel refresh pulse |

## Verification
The assertions check the following on every cycle:
- a rejected write (bad key or misaligned) raises the error flag and no strobe;
- storage only changes on an accepted write;
- the key byte never reads back nonzero;
- at most one word strobe fires at a time;
- a manager write fans out to its channel strobes.

Only the bench's scenarios can show the per-PLL bit positions of the status word and the exact reset values. The same goes for the silent discard of keyed writes to the status word and to unimplemented words, and for the zero returned on out-of-range reads. The bench shows these by comparing every cycle against a behavioural model that is driven through directed and random write streams.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 13;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int KEY_MSB   = 31;
    localparam int KEY_LSB   = 24;
    localparam int KEY_W     = KEY_MSB - KEY_LSB + 1;
    localparam logic [KEY_W-1:0] KEY_VAL = 8'h5A;

    // word map
    localparam int STAT_IDX  = 0;
    localparam int MGR_BASE  = 1;
    localparam int CTRL_BASE = 8;
    localparam int CHAN_BASE = 16;

    // bit positions inside words
    localparam int ARST_BIT  = 8;
    localparam int PDN_BIT   = 16;
    localparam int COFF_BIT  = 8;

    typedef struct packed {
        logic              hit;
        logic              bad;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] val;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] word_default(int idx, int n_pll, int n_chan);
        logic [DATA_W-1:0] d;
        d = '0;
        if (idx >= MGR_BASE && idx < MGR_BASE + n_pll)
            d[ARST_BIT] = 1'b1;
        else if (idx >= CTRL_BASE && idx < CTRL_BASE + n_pll)
            d[PDN_BIT] = 1'b1;
        else if (idx >= CHAN_BASE && idx < CHAN_BASE + n_chan)
            d[COFF_BIT] = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/clkcfg_key_gate.sv
module clkcfg_key_gate
    import clkcfg_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_req_t           req
);
    logic key_ok;
    logic aligned;

    always_comb begin
        key_ok  = (wr_data[KEY_MSB:KEY_LSB] == KEY_VAL);
        aligned = (wr_addr[1:0] == 2'b00);
        req.idx = wr_addr[ADDR_W-1:2];
        req.val = wr_data;
        req.val[KEY_MSB:KEY_LSB] = '0;
        req.hit = wr_en && key_ok && aligned;
        req.bad = wr_en && !(key_ok && aligned);
    end
endmodule

// File: rtl/clkcfg_bank.sv
module clkcfg_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_PLL  = 5,
    parameter int NUM_CHAN = 10
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           hit,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DATA_W-1:0]              val,
    output logic [NUM_REGS-1:0][DATA_W-1:0] words,
    output logic [NUM_REGS-1:0]            stb
);
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
        if (gi == STAT_IDX) begin : g_stat
            assign words[gi] = '0;
            assign stb[gi]   = 1'b0;
        end else begin : g_store
            localparam logic [DATA_W-1:0] DEF = word_default(gi, NUM_PLL, NUM_CHAN);
            logic sel;
            assign sel = hit && (idx == IDX_W'(gi));
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[gi] <= DEF;
                    stb[gi]   <= 1'b0;
                end else begin
                    stb[gi] <= sel;
                    if (sel)
                        words[gi] <= val;
                end
            end
        end
    end

    // storage only moves on an accepted write (R2)
    a_r2_hold_without_hit: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(words));
endmodule

// File: rtl/clkcfg_status.sv
module clkcfg_status #(
    parameter int NUM_PLL = 5
) (
    input  logic [NUM_PLL-1:0] arst,
    input  logic [NUM_PLL-1:0] pdn,
    output logic [NUM_PLL-1:0] locked
);
    for (genvar gp = 0; gp < NUM_PLL; gp++) begin : g_pll
        assign locked[gp] = !arst[gp] && !pdn[gp];
    end
endmodule

// File: rtl/clkcfg_refresh.sv
module clkcfg_refresh
    import clkcfg_pkg::*;
#(
    parameter int NUM_PLL    = 5,
    parameter int CH_PER_PLL = 2,
    localparam int NUM_CHAN  = NUM_PLL * CH_PER_PLL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_PLL-1:0]  pll_q,
    output logic [NUM_CHAN-1:0] chan_q
);
    for (genvar gp = 0; gp < NUM_PLL; gp++) begin : g_pll
        always_ff @(posedge clk) begin
            if (rst) pll_q[gp] <= 1'b0;
            else     pll_q[gp] <= hit && (idx == IDX_W'(MGR_BASE + gp) ||
                                          idx == IDX_W'(CTRL_BASE + gp));
        end
    end

    for (genvar gc = 0; gc < NUM_CHAN; gc++) begin : g_chan
        localparam int PARENT = gc / CH_PER_PLL;
        always_ff @(posedge clk) begin
            if (rst) chan_q[gc] <= 1'b0;
            else     chan_q[gc] <= hit && (idx == IDX_W'(CHAN_BASE + gc) ||
                                           idx == IDX_W'(MGR_BASE + PARENT));
        end
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int NUM_PLL    = 5,
    parameter int CH_PER_PLL = 2,
    localparam int NUM_CHAN  = NUM_PLL * CH_PER_PLL,
    localparam int SEL_W     = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                wr_err,
    output logic [NUM_REGS-1:0] upd_strobe,
    output logic [NUM_PLL-1:0]  pll_refresh,
    output logic [NUM_CHAN-1:0] chan_refresh
);
    wr_req_t                        req;
    logic [NUM_REGS-1:0][DATA_W-1:0] words;
    logic [NUM_PLL-1:0]             arst, pdn, locked;
    logic [IDX_W-1:0]               rd_idx;

    clkcfg_key_gate u_gate (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    clkcfg_bank #(.NUM_REGS(NUM_REGS), .NUM_PLL(NUM_PLL), .NUM_CHAN(NUM_CHAN)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .hit   (req.hit),
        .idx   (req.idx),
        .val   (req.val),
        .words (words),
        .stb   (upd_strobe)
    );

    for (genvar gp = 0; gp < NUM_PLL; gp++) begin : g_tap
        assign arst[gp] = words[MGR_BASE + gp][ARST_BIT];
        assign pdn[gp]  = words[CTRL_BASE + gp][PDN_BIT];
    end

    clkcfg_status #(.NUM_PLL(NUM_PLL)) u_status (
        .arst   (arst),
        .pdn    (pdn),
        .locked (locked)
    );

    clkcfg_refresh #(.NUM_PLL(NUM_PLL), .CH_PER_PLL(CH_PER_PLL)) u_refresh (
        .clk    (clk),
        .rst    (rst),
        .hit    (req.hit),
        .idx    (req.idx),
        .pll_q  (pll_refresh),
        .chan_q (chan_refresh)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= req.bad;
    end

    assign rd_idx = rd_addr[ADDR_W-1:2];

    always_comb begin
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00 && rd_idx < IDX_W'(NUM_REGS)) begin
            if (rd_idx == IDX_W'(STAT_IDX))
                rd_data[NUM_PLL-1:0] = locked;
            else
                rd_data = words[rd_idx[SEL_W-1:0]];
        end
    end

    a_r2_badkey_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[KEY_MSB:KEY_LSB] != KEY_VAL) |=> wr_err);

    a_r2_badkey_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[KEY_MSB:KEY_LSB] != KEY_VAL) |=>
            (upd_strobe == '0 && pll_refresh == '0 && chan_refresh == '0));

    a_r4_misaligned_flags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[1:0] != 2'b00) |=> (wr_err && upd_strobe == '0));

    a_r3_key_byte_clear: assert property (@(posedge clk) disable iff (rst)
        rd_data[KEY_MSB:KEY_LSB] == '0);

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_strobe));

    a_r8_mgr_fanout: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(MGR_BASE * 4) &&
         wr_data[KEY_MSB:KEY_LSB] == KEY_VAL) |=>
            (pll_refresh[0] && chan_refresh[0]));
endmodule

// File: tb/clkcfg_regs_bench.sv
`timescale 1ns/1ps
module clkcfg_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [12:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_err;
    logic [31:0] upd_strobe;
    logic [4:0]  pll_refresh;
    logic [9:0]  chan_refresh;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [31:0] mdl [32];

    always #4 clk = ~clk;

    clkcfg_regs u_clkcfg_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err),
        .upd_strobe(upd_strobe), .pll_refresh(pll_refresh), .chan_refresh(chan_refresh)
    );

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        for (int p = 0; p < 5; p++) begin
            mdl[1 + p] = 32'h0000_0100;
            mdl[8 + p] = 32'h0001_0000;
        end
        for (int c = 0; c < 10; c++) mdl[16 + c] = 32'h0000_0100;
    endtask

    function automatic logic [31:0] model_read(logic [12:0] a);
        int i;
        logic [31:0] r;
        i = int'(a[12:2]);
        r = 32'h0;
        if (a[1:0] != 2'b00 || i >= 32) return 32'h0;
        if (i == 0) begin
            for (int p = 0; p < 5; p++)
                r[p] = !mdl[1 + p][8] && !mdl[8 + p][16];
            return r;
        end
        return mdl[i];
    endfunction

    task automatic note(string tag, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(bit we, logic [12:0] wa, logic [31:0] wd, logic [12:0] ra, string tag);
        bit acc;
        int idx;
        logic [31:0] e_stb;
        logic [4:0]  e_pll;
        logic [9:0]  e_chan;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(posedge clk);
        acc = we && wd[31:24] == 8'h5A && wa[1:0] == 2'b00;
        idx = int'(wa[12:2]);
        e_stb = '0; e_pll = '0; e_chan = '0;
        if (acc && idx >= 1 && idx < 32) begin
            mdl[idx] = {8'h00, wd[23:0]};
            e_stb[idx] = 1'b1;
        end
        for (int p = 0; p < 5; p++)
            e_pll[p] = acc && (idx == 1 + p || idx == 8 + p);
        for (int c = 0; c < 10; c++)
            e_chan[c] = acc && (idx == 16 + c || idx == 1 + c / 2);
        @(negedge clk);
        vectors++;
        note(tag, "rd_data", rd_data, model_read(ra));
        note(tag, "upd_strobe", upd_strobe, e_stb);
        note(tag, "pll_refresh", {27'h0, pll_refresh}, {27'h0, e_pll});
        note(tag, "chan_refresh", {22'h0, chan_refresh}, {22'h0, e_chan});
        note(tag, "wr_err", {31'h0, wr_err}, {31'h0, (we && !acc)});
        wr_en = 1'b0;
    endtask

    function automatic logic [12:0] wa_of(int i);
        return 13'(i * 4);
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset contents; R9: beyond range
        for (int i = 0; i < 34; i++)
            cyc(0, '0, '0, wa_of(i), (i < 32) ? "R1" : "R9");
        // R3/R5: plain word
        cyc(1, wa_of(6), 32'h5A12_3456, wa_of(6), "R3");
        cyc(0, '0, '0, wa_of(6), "R3");
        // R2: wrong key
        cyc(1, wa_of(6), 32'hA5FF_FFFF, wa_of(6), "R2");
        cyc(1, wa_of(17), 32'h0000_0000, wa_of(17), "R2");
        // R4: misaligned keyed write
        cyc(1, 13'h019, 32'h5A00_00FF, wa_of(6), "R4");
        // R6: release PLL A then B
        cyc(1, wa_of(1), 32'h5A00_0000, wa_of(0), "R6");
        cyc(1, wa_of(8), 32'h5A00_0003, wa_of(0), "R6");
        cyc(1, wa_of(5), 32'h5A00_0000, wa_of(0), "R6");
        cyc(1, wa_of(12), 32'h5A00_0000, wa_of(0), "R6");
        cyc(1, wa_of(1), 32'h5A00_0100, wa_of(0), "R6");
        // R7: keyed writes to status and unimplemented words
        cyc(1, wa_of(0), 32'h5AFF_FFFF, wa_of(0), "R7");
        cyc(1, wa_of(40), 32'h5A00_1234, wa_of(40), "R7");
        // R8: fan-out from manager, control, channel
        cyc(1, wa_of(3), 32'h5A00_0100, wa_of(3), "R8");
        cyc(1, wa_of(10), 32'h5A01_0000, wa_of(10), "R8");
        cyc(1, wa_of(23), 32'h5A00_0042, wa_of(23), "R8");
        // R9: misaligned read
        cyc(0, '0, '0, 13'h01A, "R9");
        // mixed stream
        for (int n = 0; n < 400; n++) begin
            logic [12:0] a;
            logic [31:0] d;
            a = 13'($urandom_range(0, 35) * 4);
            if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
            d = $urandom;
            if ($urandom_range(0, 4) != 0) d[31:24] = 8'h5A;
            cyc($urandom_range(0, 3) != 0, a, d, 13'($urandom_range(0, 35) * 4), "R5");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule